// File: doc/BRIEF.md
# Dual-Rail Threshold-Logic Ripple Adder

This block adds two 4-bit operands and a carry-in, all carried as dual-rail signals, and produces a dual-rail 4-bit sum and a dual-rail carry-out. It has no clock. Every gate is a hysteretic M-of-N threshold gate, so an output rail rises only once enough of its inputs have arrived. It falls only after all of those inputs have gone low again. A result therefore appears only after the carry has really travelled through the chain.

The environment works in alternating wavefronts. It first presents a full DATA set on every input pair and waits for `data_done_o`. It then returns every input pair to NULL and waits for `null_done_o` before it presents the next DATA set. Settling time depends on the operands. A sum with no carry chain, such as 0+0, resolves at once. A sum such as 15+1, where a carry passes through every cell, needs the whole ripple. The reset input `rst_ni` forces every gate low and serves only to initialise the storage that gives the gates their hysteresis.

Top module: `dr_ripple_adder`

## Requirements
- R1: Each bit is a rail pair (`*_t`, `*_f`). True rail alone high encodes 1, false rail alone high encodes 0, and both rails low encodes NULL. No output pair ever has both rails high.
- R2: A threshold gate drives its output high only once the weighted count of its high inputs reaches its threshold. A single DATA operand (A only, with B and carry-in NULL) leaves every output rail low.
- R3: A threshold gate holds its output while any of its inputs is still high. Returning only operand A to NULL after a DATA wavefront leaves the sum, the carry-out and `data_done_o` unchanged.
- R4: For every one of the 512 combinations of A, B and carry-in, the DATA result satisfies {cout, sum} = A + B + cin.
- R5: Each sum bit stays NULL until the carry into its cell is DATA. With carry-in NULL, 14+1 leaves every sum bit and the carry-out NULL, and raising carry-in resolves all of them. With A=0 and B=0 and carry-in NULL, sum bits 3..1 and the carry-out resolve to 0 while sum bit 0 stays NULL.
- R6: `data_done_o` rises once every output pair holds DATA. It stays high until every output rail is low.
- R7: `null_done_o` is high exactly when every output rail is low.
- R8: While `rst_ni` is low, every output rail is low whatever the inputs are. When reset is released under DATA inputs, the correct result appears.
- R9: After a NULL wavefront on all inputs, every output rail returns low, `null_done_o` is high and `data_done_o` is low, before the next DATA set is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous reset of all gate state |
| a_t_i | input | 4 | Operand A, true rails |
| a_f_i | input | 4 | Operand A, false rails |
| b_t_i | input | 4 | Operand B, true rails |
| b_f_i | input | 4 | Operand B, false rails |
| cin_t_i | input | 1 | Carry-in, true rail |
| cin_f_i | input | 1 | Carry-in, false rail |
| sum_t_o | output | 4 | Sum, true rails |
| sum_f_o | output | 4 | Sum, false rails |
| cout_t_o | output | 1 | Carry-out, true rail |
| cout_f_o | output | 1 | Carry-out, false rail |
| data_done_o | output | 1 | Every output pair holds DATA |
| null_done_o | output | 1 | Every output rail is low |

## Verification
A gate that has lost its hold shows as an output pair that falls back to NULL while some inputs are still DATA. The bench sees this at once in the partial-NULL test, because `data_done_o` drops. A gate that sets too early shows up in two ways. Either both rails of a pair go high, which is flagged on the same wavefront, or a sum bit becomes valid before its carry-in is DATA, which the tests with carry-in held NULL catch. A stuck or mis-weighted gate gives a wrong decoded sum in the exhaustive sweep. If a rail never rises, the bench sees `data_done_o` stay low for that wavefront.

// File: rtl/dr_adder_pkg.sv
`timescale 1ns/1ps
package dr_adder_pkg;
  localparam int WGT_W = 2;
  localparam logic [WGT_W-1:0] WGT_ONE = 2'd1;
  localparam logic [WGT_W-1:0] WGT_TWO = 2'd2;

  typedef struct packed {
    logic t;
    logic f;
  } dr_bit_t;

  function automatic logic dr_is_data(dr_bit_t x);
    return x.t ^ x.f;
  endfunction
endpackage

// File: rtl/th_gate.sv
`timescale 1ns/1ps
// Weighted M-of-N threshold gate with hysteresis (level hold)
module th_gate
  import dr_adder_pkg::*;
#(
  parameter int N_IN = 3,
  parameter int THRESH = 2,
  parameter logic [N_IN*WGT_W-1:0] WEIGHTS = {N_IN{WGT_ONE}}
) (
  input  logic            rst_ni,
  input  logic [N_IN-1:0] in_i,
  output logic            q_o
);
  int   acc;
  logic set_c;
  logic clr_c;

  always_comb begin
    acc = 0;
    for (int i = 0; i < N_IN; i++) begin
      if (in_i[i]) acc = acc + int'(WEIGHTS[i*WGT_W +: WGT_W]);
    end
    set_c = (acc >= THRESH);
    clr_c = ~|in_i;
  end

  always_latch begin
    if (!rst_ni)    q_o <= 1'b0;
    else if (set_c) q_o <= 1'b1;
    else if (clr_c) q_o <= 1'b0;
  end
endmodule

// File: rtl/dr_fa_cell.sv
`timescale 1ns/1ps
module dr_fa_cell
  import dr_adder_pkg::*;
(
  input  logic    rst_ni,
  input  dr_bit_t a_i,
  input  dr_bit_t b_i,
  input  dr_bit_t c_i,
  output dr_bit_t s_o,
  output dr_bit_t co_o
);
  localparam logic [3*WGT_W-1:0] CARRY_W = {3{WGT_ONE}};
  // index 0 is the opposite-polarity carry-out rail, weight 2
  localparam logic [4*WGT_W-1:0] SUM_W = {WGT_ONE, WGT_ONE, WGT_ONE, WGT_TWO};

  th_gate #(.N_IN(3), .THRESH(2), .WEIGHTS(CARRY_W)) u_co_t (
    .rst_ni(rst_ni), .in_i({a_i.t, b_i.t, c_i.t}), .q_o(co_o.t));
  th_gate #(.N_IN(3), .THRESH(2), .WEIGHTS(CARRY_W)) u_co_f (
    .rst_ni(rst_ni), .in_i({a_i.f, b_i.f, c_i.f}), .q_o(co_o.f));

  th_gate #(.N_IN(4), .THRESH(3), .WEIGHTS(SUM_W)) u_s_t (
    .rst_ni(rst_ni), .in_i({a_i.t, b_i.t, c_i.t, co_o.f}), .q_o(s_o.t));
  th_gate #(.N_IN(4), .THRESH(3), .WEIGHTS(SUM_W)) u_s_f (
    .rst_ni(rst_ni), .in_i({a_i.f, b_i.f, c_i.f, co_o.t}), .q_o(s_o.f));

  logic ins_data;
  assign ins_data = dr_is_data(a_i) & dr_is_data(b_i) & dr_is_data(c_i);

  always_comb begin
    if (rst_ni) begin
      AST_SUM_RAILS_EXCL: assert (!(s_o.t && s_o.f)) else $error("sum pair both high"); // R1
      AST_CARRY_RAILS_EXCL: assert (!(co_o.t && co_o.f)) else $error("carry pair both high"); // R1
      if (ins_data && dr_is_data(co_o)) begin
        AST_CARRY_VALUE: assert (co_o.t == ((a_i.t & b_i.t) | (a_i.t & c_i.t) | (b_i.t & c_i.t)))
          else $error("carry value wrong"); // R4
      end
      if (ins_data && dr_is_data(s_o)) begin
        AST_SUM_VALUE: assert (s_o.t == (a_i.t ^ b_i.t ^ c_i.t)) else $error("sum value wrong"); // R4
      end
    end
  end
endmodule

// File: rtl/dr_completion.sv
`timescale 1ns/1ps
module dr_completion
  import dr_adder_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sum_t_i,
  input  logic [WIDTH-1:0] sum_f_i,
  input  logic             cout_t_i,
  input  logic             cout_f_i,
  output logic             data_done_o,
  output logic             null_done_o
);
  localparam int NPAIR = WIDTH + 1;
  logic [NPAIR-1:0] pair_busy;

  assign pair_busy   = {cout_t_i | cout_f_i, sum_t_i | sum_f_i};
  assign null_done_o = ~|pair_busy;

  // all-of-N gate: rises when every pair is DATA, falls when all are NULL
  th_gate #(.N_IN(NPAIR), .THRESH(NPAIR), .WEIGHTS({NPAIR{WGT_ONE}})) u_done (
    .rst_ni(rst_ni), .in_i(pair_busy), .q_o(data_done_o));
endmodule

// File: rtl/dr_ripple_adder.sv
`timescale 1ns/1ps
module dr_ripple_adder
  import dr_adder_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] a_t_i,
  input  logic [WIDTH-1:0] a_f_i,
  input  logic [WIDTH-1:0] b_t_i,
  input  logic [WIDTH-1:0] b_f_i,
  input  logic             cin_t_i,
  input  logic             cin_f_i,
  output logic [WIDTH-1:0] sum_t_o,
  output logic [WIDTH-1:0] sum_f_o,
  output logic             cout_t_o,
  output logic             cout_f_o,
  output logic             data_done_o,
  output logic             null_done_o
);
  dr_bit_t [WIDTH:0] carry;

  assign carry[0] = '{t: cin_t_i, f: cin_f_i};

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    dr_bit_t s;
    dr_fa_cell u_cell (
      .rst_ni(rst_ni),
      .a_i   ('{t: a_t_i[i], f: a_f_i[i]}),
      .b_i   ('{t: b_t_i[i], f: b_f_i[i]}),
      .c_i   (carry[i]),
      .s_o   (s),
      .co_o  (carry[i+1])
    );
    assign sum_t_o[i] = s.t;
    assign sum_f_o[i] = s.f;
  end

  assign cout_t_o = carry[WIDTH].t;
  assign cout_f_o = carry[WIDTH].f;

  dr_completion #(.WIDTH(WIDTH)) u_done (
    .rst_ni     (rst_ni),
    .sum_t_i    (sum_t_o),
    .sum_f_i    (sum_f_o),
    .cout_t_i   (cout_t_o),
    .cout_f_i   (cout_f_o),
    .data_done_o(data_done_o),
    .null_done_o(null_done_o)
  );

  logic in_all_data;
  logic out_all_data;
  assign in_all_data  = (&(a_t_i ^ a_f_i)) & (&(b_t_i ^ b_f_i)) & (cin_t_i ^ cin_f_i);
  assign out_all_data = (&(sum_t_o ^ sum_f_o)) & (cout_t_o ^ cout_f_o);

  always_comb begin
    if (rst_ni && in_all_data && out_all_data) begin
      AST_RESULT_MATCH: assert ({cout_t_o, sum_t_o} == ({1'b0, a_t_i} + {1'b0, b_t_i} + {{WIDTH{1'b0}}, cin_t_i}))
        else $error("decoded result wrong"); // R4
    end
  end
endmodule

// File: tb/dr_ripple_adder_tb_top.sv
`timescale 1ns/1ps
module dr_ripple_adder_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_ni;
  logic [W-1:0] a_t, a_f, b_t, b_f;
  logic cin_t, cin_f;
  logic [W-1:0] sum_t, sum_f;
  logic cout_t, cout_f, data_done, null_done;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dr_ripple_adder #(.WIDTH(W)) dut_i (
    .rst_ni(rst_ni), .a_t_i(a_t), .a_f_i(a_f), .b_t_i(b_t), .b_f_i(b_f),
    .cin_t_i(cin_t), .cin_f_i(cin_f), .sum_t_o(sum_t), .sum_f_o(sum_f),
    .cout_t_o(cout_t), .cout_f_o(cout_f),
    .data_done_o(data_done), .null_done_o(null_done));

  // a, b, cin, expected {cout,sum}
  localparam int NVEC = 8;
  localparam int VEC [NVEC][4] = '{
    '{0, 0, 0, 0}, '{15, 1, 0, 16}, '{15, 15, 1, 31}, '{7, 8, 1, 16},
    '{5, 10, 0, 15}, '{9, 9, 1, 19}, '{14, 1, 1, 16}, '{3, 12, 0, 15}};

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive_a(int v);
    a_t = W'(v); a_f = ~W'(v);
  endtask
  task automatic drive_b(int v);
    b_t = W'(v); b_f = ~W'(v);
  endtask
  task automatic drive_c(int v);
    cin_t = v[0]; cin_f = ~v[0];
  endtask
  task automatic drive_null();
    a_t = '0; a_f = '0; b_t = '0; b_f = '0; cin_t = 1'b0; cin_f = 1'b0;
  endtask

  function automatic int legal_out();
    return int'((&(sum_t ^ sum_f)) & (cout_t ^ cout_f) & ~|(sum_t & sum_f) & ~(cout_t & cout_f));
  endfunction

  task automatic data_phase(int a, int b, int c, int exp, bit full);
    drive_a(a); drive_b(b); drive_c(c);
    #2;
    if (full) check("R1 pairs legal", legal_out(), 1);
    check("R4 result", int'({cout_t, sum_t}), exp);
    if (full) begin
      check("R6 data_done high", int'(data_done), 1);
      check("R7 null_done low on DATA", int'(null_done), 0);
    end
  endtask

  task automatic null_phase(bit full);
    drive_null();
    #2;
    check("R9 rails low after NULL", int'({sum_t, sum_f, cout_t, cout_f}), 0);
    if (full) begin
      check("R7 null_done high", int'(null_done), 1);
      check("R9 data_done low", int'(data_done), 0);
    end
  endtask

  initial begin
    drive_a(15); drive_b(15); drive_c(1);
    rst_ni = 1'b0;
    #3;
    // R8: reset holds all rails low under DATA inputs
    check("R8 rails low in reset", int'({sum_t, sum_f, cout_t, cout_f}), 0);
    check("R8 null_done in reset", int'(null_done), 1);
    check("R8 data_done in reset", int'(data_done), 0);
    rst_ni = 1'b1;
    #2;
    check("R8 result after release", int'({cout_t, sum_t}), 31);
    check("R8 data_done after release", int'(data_done), 1);
    null_phase(1'b1);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      data_phase(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], 1'b1);
      null_phase(1'b1);
    end

    // R4: exhaustive sweep, each DATA set preceded by NULL
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 2; c++) begin
          null_phase(1'b0);
          data_phase(a, b, c, a + b + c, 1'b1);
        end
    null_phase(1'b1);

    // R2: one DATA operand alone fires nothing
    drive_a(0);
    #2;
    check("R2 single operand no output", int'({sum_t, sum_f, cout_t, cout_f}), 0);
    check("R2 null_done held", int'(null_done), 1);
    // R5: 0+0 with cin NULL kills carries; bit0 sum waits on cin
    drive_b(0);
    #2;
    check("R5 sum_f bits 3..1", int'(sum_f), 14);
    check("R5 sum_t none", int'(sum_t), 0);
    check("R5 cout resolved to 0", int'({cout_t, cout_f}), 1);
    check("R5 R6 data_done waits", int'(data_done), 0);
    drive_c(0);
    #2;
    check("R5 sum bit0 resolves", int'({cout_t, sum_t}), 0);
    check("R6 data_done after cin", int'(data_done), 1);
    null_phase(1'b1);

    // R5: 14+1 propagates through every cell, needs cin
    drive_a(14); drive_b(1);
    #2;
    check("R5 all outputs wait on cin", int'({sum_t, sum_f, cout_t, cout_f}), 0);
    drive_c(1);
    #2;
    check("R5 14+1+1 after cin", int'({cout_t, sum_t}), 16);
    check("R5 legal after cin", legal_out(), 1);
    null_phase(1'b1);

    // R3: partial NULL keeps outputs held
    data_phase(5, 10, 0, 15, 1'b1);
    a_t = '0; a_f = '0;
    #2;
    check("R3 sum held", int'({cout_t, sum_t}), 15);
    check("R3 sum_f held", int'(sum_f), 0);
    check("R3 data_done held", int'(data_done), 1);
    check("R3 null_done low", int'(null_done), 0);
    null_phase(1'b1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule